// File: doc/BRIEF.md
# Two-Wire Slave Configuration Register Bank

This block is the register bank behind a two-wire serial slave on a clock-generator control path. A host on the serial bus addresses the slave, then either streams configuration bytes into it or pulls a block of bytes back out. The bank holds a status byte, six configuration bytes, a fixed identification byte and a read-length register. The status byte combines the live level of a stop-request pin with two strap pins that are captured once, right after reset.

Every transfer is anchored at register index 0. A block write opens with a byte count, and the data bytes that follow land on consecutive indexes. A block read returns bytes from index 0 upward. The number of bytes it returns comes from the read-length register, which software can rewrite, so the host can shorten or lengthen later reads. The serial lines are oversampled by the system clock. The data line appears as a separate input, a driven value and a drive enable.

Top module: `i2c_cfg_bank`

## Requirements
- R1: After reset the data line is not driven, every configuration output byte is 0x00, and the read length is 30 bytes.
- R2: An address byte (bits 7:1 address, bit 0 set for read) is acknowledged only when its address is 7'h69. Any other address gets no acknowledge, and the slave drives nothing until the next start condition.
- R3: Index 0 is the status byte. Bits 7:4 and bit 2 read 0. Bit 3 is the current level of `pciStopN`. Bits 1:0 are the `fsStrap` value captured on the first clock after reset, and later strap changes do not alter them.
- R4: Index 7 always reads 0x1F (revision 0001 in bits 7:4, vendor 1111 in bits 3:0), whatever is written to it.
- R5: In a write, the first byte after the address is a count N. Up to N data bytes follow and go to indexes 0, 1, 2 and so on, each acknowledged. A byte stored at index k (1 to 6) appears on `cfgOut[(k-1)*8 +: 8]`, and `cfgOut` changes only through such a write.
- R6: A data byte beyond the declared count N is not acknowledged and not stored.
- R7: Data bytes sent to index 0, index 7 or any index above 8 are acknowledged but change nothing.
- R8: A block read returns bytes from index 0 upward, most significant bit first. It returns exactly as many bytes as the read length, and indexes above 8 read 0x00. After the last byte the slave leaves the data line undriven, even if the host acknowledges.
- R9: Index 8 is the read length. It is writable, and a new value sets the length of the following block reads.
- R10: A host not-acknowledge ends a block read: the slave drives nothing in the next byte slot.
- R11: A start condition at any point abandons the current transfer, and the next byte is decoded as an address.
- R12: The slave starts driving, or changes its driven bit, only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| sclI | input | 1 | Serial clock line level |
| sdaI | input | 1 | Serial data line level |
| sdaO | output | 1 | Value the slave drives on the data line |
| sdaOe | output | 1 | Drive enable for the data line |
| pciStopN | input | 1 | Live stop-request pin, mirrored into status bit 3 |
| fsStrap | input | 2 | Strap pins captured after reset into status bits 1:0 |
| cfgOut | output | 48 | Configuration bytes at indexes 1 to 6, byte 1 in the low 8 bits |

## Verification
The hardest situations to reach from the ports are the edges of the counted transfers. These are a read that the host keeps clocking past the programmed length, and a write whose data run past its own declared count. The stimulus gets there in stages. It first reprograms the read length through a complete 9-byte block write. It then reads exactly at and one byte past the new length, and it sends one byte too many in a write. Separate runs cover a host not-acknowledge in the middle of a read and a repeated start in the middle of a write, so that each early exit from the byte engine is taken.

// File: rtl/i2c_cfg_bank_pkg.sv
package i2c_cfg_bank_pkg;
  typedef struct packed {
    logic       wrEn;
    logic [7:0] wrIdx;
    logic [7:0] wrData;
    logic [7:0] rdIdx;
  } regStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK
  } busState_t;

  typedef enum logic [1:0] {
    PH_ADDR, PH_COUNT, PH_DATA
  } rxPhase_t;
endpackage

// File: rtl/i2c_cfg_bank_ctrl.sv
module i2c_cfg_bank_ctrl
  import i2c_cfg_bank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclI,
  input  logic       sdaI,
  input  logic [7:0] rdByte,
  input  logic [7:0] rdCount,
  output regStrobe_t stb,
  output logic       sdaO,
  output logic       sdaOe
);
  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclNow, sdaNow, sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclI};
      sdaSync <= {sdaSync[0], sdaI};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclNow   = sclSync[1];
  assign sdaNow   = sdaSync[1];
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  busState_t  state;
  rxPhase_t   phase;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg, wrLeft, idx, rdSent, wrIdxQ, wrDataQ;
  logic       isRead, masterAck, wrEnQ;

  assign stb = '{wrEn: wrEnQ, wrIdx: wrIdxQ, wrData: wrDataQ, rdIdx: rdSent};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase     <= PH_ADDR;
      bitCnt    <= '0;
      shiftReg  <= '0;
      wrLeft    <= '0;
      idx       <= '0;
      rdSent    <= '0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      wrEnQ     <= 1'b0;
      wrIdxQ    <= '0;
      wrDataQ   <= '0;
      sdaO      <= 1'b0;
      sdaOe     <= 1'b0;
    end else begin
      wrEnQ <= 1'b0;
      if (startDet) begin
        state  <= ST_RX;
        phase  <= PH_ADDR;
        bitCnt <= '0;
        rdSent <= '0;
        sdaOe  <= 1'b0;
      end else if (stopDet) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (sclRise && bitCnt < 4'd8) begin
              shiftReg <= {shiftReg[6:0], sdaNow};
              bitCnt   <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              unique case (phase)
                PH_ADDR: begin
                  if (shiftReg[7:1] == DEV_ADDR) begin
                    isRead <= shiftReg[0];
                    state  <= ST_RXACK;
                    sdaO   <= 1'b0;
                    sdaOe  <= 1'b1;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                PH_COUNT: begin
                  wrLeft <= shiftReg;
                  idx    <= '0;
                  phase  <= PH_DATA;
                  state  <= ST_RXACK;
                  sdaO   <= 1'b0;
                  sdaOe  <= 1'b1;
                end
                default: begin
                  if (wrLeft != 8'd0) begin
                    wrEnQ   <= 1'b1;
                    wrIdxQ  <= idx;
                    wrDataQ <= shiftReg;
                    idx     <= idx + 8'd1;
                    wrLeft  <= wrLeft - 8'd1;
                    state   <= ST_RXACK;
                    sdaO    <= 1'b0;
                    sdaOe   <= 1'b1;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (sclFall) begin
              if (phase == PH_ADDR && isRead) begin
                if (rdCount != 8'd0) begin
                  shiftReg <= rdByte;
                  sdaO     <= rdByte[7];
                  sdaOe    <= 1'b1;
                  rdSent   <= rdSent + 8'd1;
                  bitCnt   <= '0;
                  state    <= ST_TX;
                end else begin
                  sdaOe <= 1'b0;
                  state <= ST_IDLE;
                end
              end else begin
                sdaOe <= 1'b0;
                state <= ST_RX;
                if (phase == PH_ADDR) phase <= PH_COUNT;
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                sdaOe <= 1'b0;
                state <= ST_TXACK;
              end else begin
                shiftReg <= {shiftReg[6:0], 1'b0};
                sdaO     <= shiftReg[6];
                bitCnt   <= bitCnt + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (sclRise) masterAck <= ~sdaNow;
            if (sclFall) begin
              if (masterAck && rdSent < rdCount) begin
                shiftReg <= rdByte;
                sdaO     <= rdByte[7];
                sdaOe    <= 1'b1;
                rdSent   <= rdSent + 8'd1;
                bitCnt   <= '0;
                state    <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cfg_bank_regs.sv
module i2c_cfg_bank_regs
  import i2c_cfg_bank_pkg::*;
#(
  parameter int         CFG_BYTES = 6,
  parameter logic [7:0] ID_BYTE   = 8'h1F,
  parameter logic [7:0] COUNT_RST = 8'h1E
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t             stb,
  input  logic                   pciStopN,
  input  logic [1:0]             fsStrap,
  output logic [7:0]             rdByte,
  output logic [7:0]             rdCount,
  output logic [CFG_BYTES*8-1:0] cfgOut
);
  localparam logic [7:0] ID_IDX  = 8'(CFG_BYTES + 1);
  localparam logic [7:0] CNT_IDX = 8'(CFG_BYTES + 2);

  logic [CFG_BYTES*8-1:0] cfgFlat;
  logic [7:0]             countQ;
  logic [1:0]             strapQ, pciSync;
  logic                   strapDone;
  logic [7:0]             statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgFlat   <= '0;
      countQ    <= COUNT_RST;
      strapQ    <= '0;
      strapDone <= 1'b0;
      pciSync   <= 2'b11;
    end else begin
      pciSync <= {pciSync[0], pciStopN};
      if (!strapDone) begin
        strapQ    <= fsStrap;
        strapDone <= 1'b1;
      end
      if (stb.wrEn) begin
        if (stb.wrIdx == CNT_IDX) countQ <= stb.wrData;
        for (int k = 0; k < CFG_BYTES; k++) begin
          if (stb.wrIdx == 8'(k + 1)) cfgFlat[k*8 +: 8] <= stb.wrData;
        end
      end
    end
  end

  assign statusByte = {4'b0000, pciSync[1], 1'b0, strapQ};

  always_comb begin
    rdByte = 8'h00;
    if (stb.rdIdx == 8'd0)         rdByte = statusByte;
    else if (stb.rdIdx == ID_IDX)  rdByte = ID_BYTE;
    else if (stb.rdIdx == CNT_IDX) rdByte = countQ;
    for (int k = 0; k < CFG_BYTES; k++) begin
      if (stb.rdIdx == 8'(k + 1)) rdByte = cfgFlat[k*8 +: 8];
    end
  end

  assign rdCount = countQ;
  assign cfgOut  = cfgFlat;
endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank
  import i2c_cfg_bank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         CFG_BYTES = 6,
  parameter logic [7:0] ID_BYTE   = 8'h1F,
  parameter logic [7:0] COUNT_RST = 8'h1E
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclI,
  input  logic                   sdaI,
  output logic                   sdaO,
  output logic                   sdaOe,
  input  logic                   pciStopN,
  input  logic [1:0]             fsStrap,
  output logic [CFG_BYTES*8-1:0] cfgOut
);
  regStrobe_t regStb;
  logic [7:0] rdByte, rdCount;

  i2c_cfg_bank_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclI(sclI), .sdaI(sdaI),
    .rdByte(rdByte), .rdCount(rdCount), .stb(regStb),
    .sdaO(sdaO), .sdaOe(sdaOe)
  );

  i2c_cfg_bank_regs #(
    .CFG_BYTES(CFG_BYTES), .ID_BYTE(ID_BYTE), .COUNT_RST(COUNT_RST)
  ) u_regs (
    .clk(clk), .rstN(rstN), .stb(regStb), .pciStopN(pciStopN),
    .fsStrap(fsStrap), .rdByte(rdByte), .rdCount(rdCount), .cfgOut(cfgOut)
  );
endmodule

// File: rtl/i2c_cfg_bank_chk.sv
module i2c_cfg_bank_chk #(
  parameter int         CFG_BYTES = 6,
  parameter logic [7:0] ID_BYTE   = 8'h1F
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   sclI,
  input logic                   sdaO,
  input logic                   sdaOe,
  input logic [CFG_BYTES*8-1:0] cfgOut,
  input logic                   wrEn,
  input logic [7:0]             rdIdx,
  input logic [7:0]             rdByte
);
  localparam logic [7:0] ID_IDX = 8'(CFG_BYTES + 1);

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclI); // R12
  AST_BIT_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe && $past(sdaOe) && !$stable(sdaO)) |-> !sclI); // R12
  AST_CFG_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgOut) |-> $past(wrEn)); // R5
  AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx == 8'd0) |-> (rdByte[7:4] == 4'd0 && !rdByte[2])); // R3
  AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx == ID_IDX) |-> (rdByte == ID_BYTE)); // R4
endmodule

bind i2c_cfg_bank i2c_cfg_bank_chk #(.CFG_BYTES(CFG_BYTES), .ID_BYTE(ID_BYTE)) u_chk (
  .clk(clk), .rstN(rstN), .sclI(sclI), .sdaO(sdaO), .sdaOe(sdaOe),
  .cfgOut(cfgOut), .wrEn(regStb.wrEn), .rdIdx(regStb.rdIdx), .rdByte(rdByte)
);

// File: tb/i2c_cfg_bank_tb.sv
module i2c_cfg_bank_tb;
  localparam int H = 10;
  localparam int CFGN = 6;
  localparam logic [6:0] ADDR = 7'h69;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic pciStopN = 1'b1;
  logic [1:0] fsStrap = 2'b10;
  logic sdaO, sdaOe, sdaLine;
  logic [CFGN*8-1:0] cfgOut;

  assign sdaLine = mSda & (sdaOe ? sdaO : 1'b1);

  i2c_cfg_bank u_dut (
    .clk(clk), .rstN(rstN), .sclI(mScl), .sdaI(sdaLine), .sdaO(sdaO),
    .sdaOe(sdaOe), .pciStopN(pciStopN), .fsStrap(fsStrap), .cfgOut(cfgOut)
  );

  int nChecks = 0, nFails = 0;
  int refReg[0:8];
  logic [1:0] refStrap = 2'b10;
  bit cmpEn = 1'b0;
  logic prevScl = 1'b1, prevOe = 1'b0, prevO = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [CFGN*8-1:0] expCfg();
    logic [CFGN*8-1:0] v;
    for (int k = 0; k < CFGN; k++) v[k*8 +: 8] = 8'(refReg[k+1]);
    return v;
  endfunction

  function automatic int expByte(input int i);
    if (i == 0) return {4'b0, pciStopN, 1'b0, refStrap};
    if (i >= 1 && i <= 6) return refReg[i];
    if (i == 7) return 8'h1F;
    if (i == 8) return refReg[8];
    return 0;
  endfunction

  function automatic void modelWrite(input int i, input int v);
    if ((i >= 1 && i <= 6) || i == 8) refReg[i] = v;
  endfunction

  // reference comparison on every clock
  always @(negedge clk) begin
    if (cmpEn) begin
      nChecks++;
      if (cfgOut !== expCfg()) begin
        nFails++;
        $display("FAIL R5: cfgOut actual %0h expected %0h", cfgOut, expCfg());
      end
      if (mScl && prevScl) begin
        nChecks++;
        if ((sdaOe && !prevOe) || (sdaOe && prevOe && sdaO != prevO)) begin
          nFails++;
          $display("FAIL R12: sda drive changed with scl high, actual %0b expected %0b", sdaO, prevO);
        end
      end
    end
    prevScl = mScl; prevOe = sdaOe; prevO = sdaO;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; wt(H); mScl = 1'b1; wt(H); mSda = 1'b0; wt(H); mScl = 1'b0;
  endtask

  task automatic busStop();
    mSda = 1'b0; wt(H); mScl = 1'b1; wt(H); mSda = 1'b1; wt(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; wt(H); mScl = 1'b1; wt(H); mScl = 1'b0;
    end
    mSda = 1'b1; wt(H); mScl = 1'b1; wt(H/2);
    acked = !sdaLine;
    wt(H/2); mScl = 1'b0;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b, output bit drove);
    drove = 1'b0; mSda = 1'b1; b = '0;
    for (int i = 0; i < 8; i++) begin
      wt(H); mScl = 1'b1; wt(H/2);
      b = {b[6:0], sdaLine};
      if (sdaOe) drove = 1'b1;
      wt(H/2); mScl = 1'b0;
    end
    wt(2); mSda = ackIt ? 1'b0 : 1'b1;
    wt(H); mScl = 1'b1; wt(H); mScl = 1'b0; wt(2); mSda = 1'b1;
  endtask

  task automatic blockWrite(input int vals[$], input int cnt, input int extra);
    bit a;
    busStart();
    sendByte({ADDR, 1'b0}, a); chk("R2 write address ack", a, 1);
    sendByte(8'(cnt), a);      chk("R5 count ack", a, 1);
    foreach (vals[i]) begin
      cmpEn = 1'b0;
      sendByte(8'(vals[i]), a);
      chk("R5 R7 data ack", a, 1);
      modelWrite(i, vals[i]);
      cmpEn = 1'b1;
    end
    if (extra >= 0) begin
      sendByte(8'(extra), a); chk("R6 byte past count not acked", a, 0);
    end
    busStop();
  endtask

  task automatic blockRead(input int n, input int nackAt);
    bit a, d;
    logic [7:0] b;
    busStart();
    sendByte({ADDR, 1'b1}, a); chk("R2 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != nackAt, b, d);
      chk($sformatf("R8 R3 R4 read byte %0d", i), b, expByte(i));
      if (i == nackAt) break;
    end
    recvByte(1'b1, b, d);
    if (nackAt >= 0) chk("R10 released after host nack", d, 0);
    else chk("R8 R9 released after count", d, 0);
    busStop();
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    bit a;
    logic [7:0] b;
    bit d;
    for (int i = 0; i < 9; i++) refReg[i] = 0;
    refReg[8] = 30;
    wt(5); rstN = 1'b1; wt(3);
    fsStrap = 2'b01; // R3: must not be picked up
    chk("R1 sda released", sdaOe, 0);
    chk("R1 cfgOut zero", cfgOut, 0);
    cmpEn = 1'b1;

    // R2: foreign address
    busStart();
    sendByte({7'h12, 1'b0}, a); chk("R2 foreign address nack", a, 0);
    sendByte(8'hAA, a);         chk("R2 silent after foreign address", a, 0);
    busStop();

    // R1 R8: default length 30
    blockRead(30, -1);

    // R5 R6 R7 R9: full write, count register set to 9
    blockWrite('{8'hFF, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h00, 8'h09}, 9, 8'h77);
    chk("R5 cfgOut after write", cfgOut, 48'h665544332211);

    pciStopN = 1'b0; wt(10);
    blockRead(9, -1); // R3 R4 R7 R9

    // R7 R9: shorter length and write past index 8 ignored
    blockWrite('{8'h00, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'h55, 8'h03, 8'hEE}, 10, -1);
    chk("R7 cfgOut after second write", cfgOut, 48'hA6A5A4A3A2A1);

    // R10: host nack after second byte
    blockRead(3, 1);
    // R9: exactly three bytes
    blockRead(3, -1);

    // R11: repeated start mid write
    busStart();
    sendByte({ADDR, 1'b0}, a); chk("R11 address ack", a, 1);
    sendByte(8'd2, a);         chk("R11 count ack", a, 1);
    sendByte(8'h5A, a);        chk("R11 data ack", a, 1);
    busStart();
    sendByte({ADDR, 1'b1}, a); chk("R11 restart read address ack", a, 1);
    recvByte(1'b1, b, d);      chk("R11 status after restart", b, expByte(0));
    recvByte(1'b0, b, d);      chk("R11 index 1 after restart", b, expByte(1));
    busStop();
    chk("R11 cfgOut untouched", cfgOut, 48'hA6A5A4A3A2A1);

    wt(20);
    finishRun();
  end
endmodule